// File: doc/BRIEF.md
# Debug Halt and Access Controller

This block is the in-circuit-emulation front end of an 8-bit microcontroller core. It follows the core's machine cycle as six states, S1 to S6, with one state per clock. A debugger raises an asynchronous halt request. The block synchronizes that request and samples it at the end of S1. When the request is seen, the core freezes in S2 and an emulation indicator goes high. On that same edge the opcode being fetched is latched into the instruction register without being decoded, and the program counter steps past it.

While the core is frozen, the debugger uses a separate port to reach the internal state. This port has an address-space byte, a register or RAM address byte, write data, read data with a drive enable, and active-low read and write strobes. The debugger can read and write the special-function registers, the program counter and the 256-byte internal RAM. With the space-select input high, the debugger works on external memory instead. In that case the read data bus is not driven, and a mask register decides which pins of the high address port float.

When the halt request falls, the instruction register is forced to the no-operation opcode and the core restarts from S2. The indicator stays high until the end of S4 of that resumed cycle. The block never enters emulation while the core is powered down.

Top module: `dbg_halt_ctl`

## Requirements
- R1: After reset, `mc_state` is S1 (the states S1..S6 are encoded 1..6), `emu` is 0, `instr_reg` is 00H, `fetch_addr` is 0000H, and the high-port mask reads FFH. While the core is running, `mc_state` steps S1→S2→…→S6→S1 on each clock, and `s1_strobe` is 1 exactly while the state is S1.
- R2: `halt_req` passes through a two-flop synchronizer. It is sampled at the clock edge that ends S1. If it is high there, `emu` rises on that edge and `mc_state` then holds at 2 (S2), with `s1_strobe` low, for as long as the core stays halted.
- R3: At each edge that ends S1 while the core is running, including the entry edge, `instr_reg` loads the `fetch_opcode` value presented during that S1 and `fetch_addr` increments by one.
- R4: Debug reads drive `dbg_rdata_oe`=1 only while the core is halted, `space_sel`=0 and `dbg_rd_n`=0. `dbg_addr_hi`=00H selects the SFR/PC space, 01H selects internal RAM, and any other value reads 00H.
- R5: A debug write stores `dbg_wdata` at each clock edge where the core is halted, `space_sel`=0 and `dbg_wr_n`=0. Writes are ignored while the core runs or while `space_sel`=1.
- R6: In the SFR space, A3H is the PC low byte and A4H is the PC high byte. A PC written during a halt is the base of the first fetch after resume: `fetch_addr` becomes the written value plus one at the first end of S1.
- R7: General SFRs are stored at addresses 80H..9FH. Reads of any other SFR address apart from A3H..A5H return 00H, and writes to those addresses are ignored.
- R8: When the synchronized request is low while halted, `instr_reg` becomes 00H and the sequencer resumes from S2. `emu` stays high through S2, S3 and S4 and falls at the edge that ends S4, so it first reads 0 in S5.
- R9: While `pwr_down`=1 the sequencer is frozen and emulation is never entered, even with `halt_req` high.
- R10: SFR A5H is the high-port mask, reset to FFH. While halted with `space_sel`=1, `hi_port_z[i]` equals mask bit i (1 = pin floats), and the read bus is undriven. In every other case `hi_port_z` is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Asynchronous emulation request, active high |
| pwr_down | input | 1 | Core is in power-down |
| fetch_opcode | input | 8 | Opcode at the current fetch address |
| space_sel | input | 1 | 0 = internal registers/RAM, 1 = external memory |
| dbg_addr_hi | input | 8 | Debug space select (00H SFR/PC, 01H RAM) |
| dbg_addr_lo | input | 8 | Debug register or RAM address |
| dbg_rd_n | input | 1 | Debug read strobe, active low |
| dbg_wr_n | input | 1 | Debug write strobe, active low |
| dbg_wdata | input | 8 | Debug write data (inbound half of data bus) |
| dbg_rdata | output | 8 | Debug read data (outbound half of data bus) |
| dbg_rdata_oe | output | 1 | Drive enable for the debug data bus |
| emu | output | 1 | Emulation-mode indicator |
| s1_strobe | output | 1 | High during a running S1 state |
| mc_state | output | 3 | Machine-cycle state, 1..6 |
| instr_reg | output | 8 | Instruction register |
| fetch_addr | output | 16 | Program counter |
| hi_port_z | output | 8 | Per-pin float enable for the high address port |

## Verification
A wrong halt flag shows up at once: `mc_state` stops advancing, or keeps advancing, within one cycle, and `s1_strobe` disappears. A wrong exit counter moves the falling edge of `emu` off the S4/S5 boundary, which the bench sees within four cycles of the release. A corrupted program counter or instruction register appears on `fetch_addr` and `instr_reg` at the next end of S1, or when the PC is read back through A3H/A4H. Faults in RAM, SFR or mask storage are only visible when the location is read back on the debug port, or, for the mask, on `hi_port_z` the first time the core halts with `space_sel` high.

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl #(
  parameter logic [7:0] SFR_BASE    = 8'h80,
  parameter int         SFR_COUNT   = 32,
  parameter int         RAM_DEPTH   = 256,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt_req,
  input  logic        pwr_down,
  input  logic [7:0]  fetch_opcode,
  input  logic        space_sel,
  input  logic [7:0]  dbg_addr_hi,
  input  logic [7:0]  dbg_addr_lo,
  input  logic        dbg_rd_n,
  input  logic        dbg_wr_n,
  input  logic [7:0]  dbg_wdata,
  output logic [7:0]  dbg_rdata,
  output logic        dbg_rdata_oe,
  output logic        emu,
  output logic        s1_strobe,
  output logic [2:0]  mc_state,
  output logic [7:0]  instr_reg,
  output logic [15:0] fetch_addr,
  output logic [7:0]  hi_port_z
);
  localparam int         SFR_AW  = $clog2(SFR_COUNT);
  localparam int         RAM_AW  = $clog2(RAM_DEPTH);
  localparam logic [8:0] SFR_END = 9'(SFR_COUNT);
  localparam logic [8:0] RAM_END = 9'(RAM_DEPTH);
  localparam logic [2:0] S1 = 3'd1, S2 = 3'd2, S4 = 3'd4, S5 = 3'd5, S6 = 3'd6;
  localparam logic [7:0] A_PCL = 8'hA3, A_PCH = 8'hA4, A_MASK = 8'hA5;

  logic [SYNC_STAGES-1:0] sync_q;
  logic        halt_s, halted, exiting, emu_q;
  logic [2:0]  st;
  logic [7:0]  ir, mask;
  logic [15:0] pc;
  logic [7:0]  sfr [SFR_COUNT];
  logic [7:0]  ram [RAM_DEPTH];
  logic [7:0]  rd_mux;

  always_ff @(posedge clk)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], halt_req};
  assign halt_s = sync_q[SYNC_STAGES-1];

  wire run      = !halted && !pwr_down;
  wire s1_end   = run && st == S1;
  wire enter    = s1_end && halt_s && !exiting;
  wire leave    = halted && !halt_s;
  wire s4_end   = exiting && run && st == S4;
  wire acc      = halted && !space_sel;
  wire wr       = acc && !dbg_wr_n;
  wire sel_sfr  = dbg_addr_hi == 8'h00;
  wire sel_ram  = dbg_addr_hi == 8'h01;
  wire special  = dbg_addr_lo == A_PCL || dbg_addr_lo == A_PCH || dbg_addr_lo == A_MASK;

  wire [8:0] sfr_off = {1'b0, dbg_addr_lo} - {1'b0, SFR_BASE};
  wire       sfr_hit = !special && !sfr_off[8] && sfr_off < SFR_END;
  wire [SFR_AW-1:0] sfr_idx = sfr_off[SFR_AW-1:0];
  wire       ram_hit = {1'b0, dbg_addr_lo} < RAM_END;
  wire [RAM_AW-1:0] ram_idx = dbg_addr_lo[RAM_AW-1:0];

  always_ff @(posedge clk)
    if (!rst_n)      st <= S1;
    else if (leave)  st <= S2;
    else if (run)    st <= (st == S6) ? S1 : st + 3'd1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      halted <= 1'b0; exiting <= 1'b0; emu_q <= 1'b0;
    end else begin
      if (enter)      halted <= 1'b1;
      else if (leave) halted <= 1'b0;
      if (leave)       exiting <= 1'b1;
      else if (s4_end) exiting <= 1'b0;
      if (enter)       emu_q <= 1'b1;
      else if (s4_end) emu_q <= 1'b0;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      ir <= 8'h00; pc <= 16'h0000;
    end else begin
      if (s1_end) begin
        ir <= fetch_opcode;
        pc <= pc + 16'd1;
      end else if (leave) begin
        ir <= 8'h00;
      end
      if (wr && sel_sfr && dbg_addr_lo == A_PCL) pc[7:0]  <= dbg_wdata;
      if (wr && sel_sfr && dbg_addr_lo == A_PCH) pc[15:8] <= dbg_wdata;
    end

  always_ff @(posedge clk)
    if (!rst_n) mask <= 8'hFF;
    else if (wr && sel_sfr && dbg_addr_lo == A_MASK) mask <= dbg_wdata;

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < SFR_COUNT; i++) sfr[i] <= 8'h00;
    end else if (wr && sel_sfr && sfr_hit) begin
      sfr[sfr_idx] <= dbg_wdata;
    end

  always_ff @(posedge clk)
    if (wr && sel_ram && ram_hit) ram[ram_idx] <= dbg_wdata;

  always_comb begin
    rd_mux = 8'h00;
    if (sel_sfr) begin
      case (dbg_addr_lo)
        A_PCL:   rd_mux = pc[7:0];
        A_PCH:   rd_mux = pc[15:8];
        A_MASK:  rd_mux = mask;
        default: if (sfr_hit) rd_mux = sfr[sfr_idx];
      endcase
    end else if (sel_ram && ram_hit) begin
      rd_mux = ram[ram_idx];
    end
  end

  assign dbg_rdata_oe = acc && !dbg_rd_n;
  assign dbg_rdata    = dbg_rdata_oe ? rd_mux : 8'h00;
  assign emu          = emu_q;
  assign s1_strobe    = s1_end;
  assign mc_state     = st;
  assign instr_reg    = ir;
  assign fetch_addr   = pc;
  assign hi_port_z    = (halted && space_sel) ? mask : 8'h00;

  AST_HOLD_S2: assert property (@(posedge clk) disable iff (!rst_n) halted |-> (st == S2 && emu_q)); // R2
  AST_ENTRY_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) $rose(halted) |-> pc == 16'($past(pc) + 16'd1)); // R3
  AST_EXIT_NOP: assert property (@(posedge clk) disable iff (!rst_n) $fell(halted) |-> ir == 8'h00); // R8
  AST_EMU_FALL_S5: assert property (@(posedge clk) disable iff (!rst_n) $fell(emu_q) |-> st == S5); // R8
  AST_NO_PD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (!halted && pwr_down) |=> !halted); // R9
  AST_BUS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n) space_sel |-> !dbg_rdata_oe); // R10
  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !halted |-> hi_port_z == 8'h00); // R10
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) st >= S1 && st <= S6); // R1
endmodule

// File: tb/dbg_halt_ctl_tb_top.sv
module dbg_halt_ctl_tb_top;
  logic clk = 0, rst_n = 0, halt_req = 0, pwr_down = 0, space_sel = 0;
  logic dbg_rd_n = 1, dbg_wr_n = 1;
  logic [7:0] fetch_opcode = 8'h11, dbg_addr_hi = 0, dbg_addr_lo = 0, dbg_wdata = 0;
  logic [7:0] dbg_rdata, instr_reg, hi_port_z;
  logic dbg_rdata_oe, emu, s1_strobe;
  logic [2:0] mc_state;
  logic [15:0] fetch_addr;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [7:0]  s1_op;
  logic [15:0] s1_pc;
  logic [7:0]  ram_m [256];
  logic        ram_v [256];
  logic [7:0]  sfr_m [32];
  logic [7:0]  mask_m;

  dbg_halt_ctl dut_i (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    fetch_opcode = 8'($urandom) | 8'h01;
    if (s1_strobe) begin s1_op = fetch_opcode; s1_pc = fetch_addr; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dwrite(logic [7:0] hi, logic [7:0] lo, logic [7:0] d);
    dbg_addr_hi = hi; dbg_addr_lo = lo; dbg_wdata = d; dbg_wr_n = 0;
    step(1);
    dbg_wr_n = 1;
  endtask

  task automatic dread(logic [7:0] hi, logic [7:0] lo, output logic [7:0] d, output logic oe);
    dbg_addr_hi = hi; dbg_addr_lo = lo; dbg_rd_n = 0;
    #1 d = dbg_rdata; oe = dbg_rdata_oe;
    dbg_rd_n = 1;
    step(1);
  endtask

  task automatic do_halt();
    logic [2:0] prev;
    prev = mc_state;
    halt_req = 1;
    for (int i = 0; i < 20; i++) begin
      prev = mc_state;
      step(1);
      if (emu) break;
    end
    check("R2 emu rise", emu, 1);
    check("R2 entry edge ends S1", prev, 1);
    check("R2 hold S2", mc_state, 2);
    check("R3 ir at entry", instr_reg, s1_op);
    check("R3 pc at entry", fetch_addr, 16'(s1_pc + 1));
  endtask

  task automatic do_release(logic [15:0] pc_w);
    halt_req = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (mc_state == 3) break;
    end
    check("R8 resumed S3", mc_state, 3);
    check("R8 ir NOP", instr_reg, 8'h00);
    check("R8 emu high in S3", emu, 1);
    step(1);
    check("R8 emu high in S4", emu, 1);
    step(1);
    check("R8 state S5", mc_state, 5);
    check("R8 emu low in S5", emu, 0);
    check("R10 no float after resume", hi_port_z, 8'h00);
    while (mc_state != 1) step(1);
    step(1);
    check("R6 resume pc", fetch_addr, 16'(pc_w + 1));
    check("R3 ir after resume", instr_reg, s1_op);
  endtask

  initial begin
    logic [7:0] d;
    logic oe;
    logic [2:0] st0;
    logic [15:0] pc0, pc_w;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) ram_v[i] = 0;
    for (int i = 0; i < 32; i++) sfr_m[i] = 0;
    mask_m = 8'hFF;
    step(3);
    rst_n = 1;
    #1;
    check("R1 reset state", mc_state, 1);
    check("R1 reset emu", emu, 0);
    check("R1 reset ir", instr_reg, 0);
    check("R1 reset pc", fetch_addr, 0);
    check("R10 reset no float", hi_port_z, 0);
    step(1);
    for (int i = 0; i < 14; i++) begin
      st0 = mc_state;
      check("R1 strobe", s1_strobe, st0 == 1);
      step(1);
      check("R1 next state", mc_state, (st0 == 6) ? 1 : st0 + 1);
    end
    pc0 = fetch_addr;
    step(6);
    check("R3 pc per cycle", fetch_addr, 16'(pc0 + 1));

    do_halt();
    step(8);
    check("R2 still S2", mc_state, 2);
    check("R2 no strobe", s1_strobe, 0);
    check("R2 pc frozen", fetch_addr, 16'(s1_pc + 1));

    dread(8'h00, 8'hA5, d, oe);
    check("R10 mask reset FF", d, 8'hFF);
    check("R4 oe on read", oe, 1);
    dread(8'h00, 8'hA3, d, oe);
    check("R6 read PCL", d, 8'(s1_pc + 1));
    dread(8'h00, 8'hA4, d, oe);
    check("R6 read PCH", d, 8'((s1_pc + 1) >> 8));
    dwrite(8'h00, 8'hC0, 8'h5A);
    dread(8'h00, 8'hC0, d, oe);
    check("R7 unimplemented reads 00", d, 8'h00);
    dwrite(8'h00, 8'h9F, 8'hC3); sfr_m[31] = 8'hC3;
    dread(8'h00, 8'h9F, d, oe);
    check("R7 SFR 9F", d, 8'hC3);
    dwrite(8'h01, 8'h00, 8'hA7); ram_m[0] = 8'hA7; ram_v[0] = 1;
    dwrite(8'h01, 8'hFF, 8'h3C); ram_m[255] = 8'h3C; ram_v[255] = 1;
    dread(8'h01, 8'h00, d, oe);
    check("R4 RAM 00", d, 8'hA7);
    dread(8'h01, 8'hFF, d, oe);
    check("R4 RAM FF", d, 8'h3C);
    dread(8'h02, 8'h00, d, oe);
    check("R4 other space reads 00", d, 8'h00);
    dread(8'h00, 8'h9F, d, oe);
    check("R4 SFR space not RAM", d, 8'hC3);

    space_sel = 1;
    #1 check("R10 float with mask FF", hi_port_z, 8'hFF);
    dread(8'h01, 8'h00, d, oe);
    check("R10 bus undriven", oe, 0);
    dwrite(8'h01, 8'h00, 8'h99);
    space_sel = 0;
    dwrite(8'h00, 8'hA5, 8'h3F); mask_m = 8'h3F;
    #1 check("R10 no float space low", hi_port_z, 8'h00);
    space_sel = 1;
    #1 check("R10 float mask 3F", hi_port_z, 8'h3F);
    space_sel = 0;
    dread(8'h01, 8'h00, d, oe);
    check("R5 write ignored with space_sel", d, 8'hA7);

    pc_w = 16'h0200;
    dwrite(8'h00, 8'hA3, pc_w[7:0]);
    dwrite(8'h00, 8'hA4, pc_w[15:8]);
    do_release(pc_w);

    dwrite(8'h01, 8'h00, 8'h42);
    dwrite(8'h00, 8'h9F, 8'h42);
    check("R5 no drive while running", dbg_rdata_oe, 0);

    pwr_down = 1;
    halt_req = 1;
    st0 = mc_state;
    step(20);
    check("R9 frozen state", mc_state, st0);
    check("R9 no emulation", emu, 0);
    check("R9 no strobe", s1_strobe, 0);
    pwr_down = 0;
    do_halt();
    dread(8'h01, 8'h00, d, oe);
    check("R5 running write ignored RAM", d, 8'hA7);
    dread(8'h00, 8'h9F, d, oe);
    check("R5 running write ignored SFR", d, 8'hC3);
    dread(8'h00, 8'hA5, d, oe);
    check("R10 mask kept", d, mask_m);
    pc_w = fetch_addr;
    do_release(pc_w);

    for (int r = 0; r < 3; r++) begin
      do_halt();
      for (int k = 0; k < 16; k++) begin
        logic [7:0] a, v;
        a = 8'($urandom); v = 8'($urandom);
        dwrite(8'h01, a, v); ram_m[a] = v; ram_v[a] = 1;
        a = 8'($urandom_range(31, 0)); v = 8'($urandom);
        dwrite(8'h00, 8'h80 + a, v); sfr_m[a] = v;
      end
      for (int k = 0; k < 16; k++) begin
        logic [7:0] a;
        a = 8'($urandom);
        if (ram_v[a]) begin
          dread(8'h01, a, d, oe);
          check("R4 random RAM", d, ram_m[a]);
        end
        a = 8'($urandom_range(31, 0));
        dread(8'h00, 8'h80 + a, d, oe);
        check("R7 random SFR", d, sfr_m[a]);
      end
      pc_w = 16'($urandom);
      dwrite(8'h00, 8'hA3, pc_w[7:0]);
      dwrite(8'h00, 8'hA4, pc_w[15:8]);
      do_release(pc_w);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule